// File: doc/BRIEF.md
# CAN Fault Confinement Tracker with Status Interrupt

This block keeps the fault-confinement state of one CAN node. The protocol engine beside it sends single-cycle event pulses: frame sent, frame received, a new 3-bit last-error code, and the error and success events that move the transmit and receive error counters. From these pulses the block keeps both counters and derives the warning, error-passive and bus-off flags.

Software sees the state through two read-only words on a simple read port. The first is a status word with the OK bits, the error code and the three confinement flags. The second is a counter word with both counts and a receive-passive flag. Software may overwrite the OK bits and the error code.

One interrupt line reports pending events. A change of warning or bus-off raises it when the error enable is on. A change of the OK bits or the error code caused by the engine raises it when the status enable is on. A read of the status word clears it.

Top module: `can_fault_status`

## Requirements
- R1: After a synchronous reset, both counters, all flags, the status fields, `irq` and `rd_data` are 0.
- R2: The transmit counter adds 8 on `tx_err_ev` and subtracts 1 on `tx_good_ev`, and never goes below 0. When both pulses come in the same cycle, only the error step is applied.
- R3: In one cycle the receive counter adds 1 for `rx_err_ev`, adds 8 for `rx_dom_ev` and subtracts 1 for `rx_good_ev`, all summed together. The result is clamped to the range 0 to 255.
- R4: Bus-off (status bit 7) is entered when the transmit count would exceed 255. It stays set until reset, and all counter events are ignored while it is set.
- R5: The warning flag (status bit 6) is 1 when either counter is at least 96, and 0 when both are below 96.
- R6: Error-passive (status bit 5) is 1 when either counter is at least 128 and bus-off is clear. The receive-passive flag (counter-word bit 15) is 1 exactly when the receive count is at least 128.
- R7: The counter word (`rd_addr`=1) holds the transmit count in bits 7:0, reading 255 while the internal count is above 255. It holds the low 7 bits of the receive count in bits 14:8 and receive-passive in bit 15. Bits 31:16 are 0.
- R8: The status word (`rd_addr`=0) holds the last-error code in bits 2:0, transmit-OK in bit 3 and receive-OK in bit 4. `tx_done` and `rx_done` set their OK bit, and `lec_valid` loads `lec_code`. `stat_wr` replaces bits 4:0 with `wr_data[4:0]`, and bits 31:8 read 0.
- R9: When `err_ie` is 1, a change of warning or bus-off sets `irq` at the clock edge after the flag changed. When `err_ie` is 0, such a change does not set it.
- R10: When `stat_ie` is 1, an engine event that changes the OK bits or the error code sets `irq` at the same edge. An event that leaves these fields unchanged does not set it, and neither does any such event when `stat_ie` is 0.
- R11: A change of error-passive alone never sets `irq`. A software write to the status word never sets it either.
- R12: A status-word read clears `irq`, but a counter-word read does not. If an interrupt-raising event falls in the same cycle as a status read, `irq` stays 1.
- R13: `rd_data` is loaded at the edge where `rd_en` is 1, with the value the word had before that edge. It holds its value while `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_done | input | 1 | Frame transmitted; sets transmit-OK |
| rx_done | input | 1 | Frame received; sets receive-OK |
| lec_valid | input | 1 | Load a new last-error code |
| lec_code | input | 3 | Last-error code value |
| tx_err_ev | input | 1 | Transmit error event (+8) |
| tx_good_ev | input | 1 | Transmit success event (-1) |
| rx_err_ev | input | 1 | Receive error event (+1) |
| rx_dom_ev | input | 1 | Dominant bit after error flag (+8) |
| rx_good_ev | input | 1 | Receive success event (-1) |
| err_ie | input | 1 | Error interrupt enable |
| stat_ie | input | 1 | Status-change interrupt enable |
| stat_wr | input | 1 | Software write strobe for status bits 4:0 |
| wr_data | input | 32 | Software write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 1 | 0 selects the status word, 1 the counter word |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Pending interrupt |

## Verification
The bench drives the counters through their saturation points. A transmit count that falls below zero, a receive count that drops the +8 step when several events come together, or a count that keeps moving after bus-off would each show up as a wrong counter word. The warning, error-passive and bus-off flags are driven one by one. A design that raises an interrupt when only error-passive changes, or when software writes the status word, leaves `irq` high where the bench expects 0. Two further cases are covered: an interrupt event in the same cycle as a status read, which a naive clear loses, and a counter-word read, which a design that decodes the address too loosely would let clear the interrupt.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  // status word field positions
  localparam int LEC_W       = 3;
  localparam int ST_LEC_LSB  = 0;
  localparam int ST_TXOK     = 3;
  localparam int ST_RXOK     = 4;
  localparam int ST_EPASS    = 5;
  localparam int ST_WARN     = 6;
  localparam int ST_BOFF     = 7;
  // counter word field positions
  localparam int TEC_LSB     = 0;
  localparam int TEC_FW      = 8;
  localparam int REC_LSB     = 8;
  localparam int REC_FW      = 7;
  localparam int CW_RXPASS   = 15;
  // read addresses
  localparam logic ADDR_STAT = 1'b0;
  localparam logic ADDR_CNT  = 1'b1;

  typedef struct packed {
    logic             rxok;
    logic             txok;
    logic [LEC_W-1:0] lec;
  } stat_fields_t;

  typedef struct packed {
    logic boff;
    logic warn;
    logic epass;
    logic rxpass;
  } conf_flags_t;
endpackage

// File: rtl/can_fc_counters.sv
module can_fc_counters #(
  parameter int TX_W         = 9,
  parameter int RX_W         = 8,
  parameter int TX_STEP      = 8,
  parameter int RX_DOM_STEP  = 8,
  parameter int BUSOFF_LIMIT = 255
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tx_err_ev,
  input  logic            tx_good_ev,
  input  logic            rx_err_ev,
  input  logic            rx_dom_ev,
  input  logic            rx_good_ev,
  output logic [TX_W-1:0] tx_cnt,
  output logic [RX_W-1:0] rx_cnt,
  output logic            bus_off
);
  localparam int TX_MAX = (1 << TX_W) - 1;
  localparam int RX_MAX = (1 << RX_W) - 1;
  localparam int SUM_W  = RX_W + 2;

  logic [TX_W:0]     tx_sum;
  logic [TX_W-1:0]   tx_next;
  logic [SUM_W-1:0]  rx_up;
  logic [SUM_W-1:0]  rx_dn;
  logic [RX_W-1:0]   rx_next;
  logic              boff_next;

  // transmit: error step wins over success, saturate high, floor at 0
  always_comb begin
    tx_sum  = {1'b0, tx_cnt} + (TX_W+1)'(TX_STEP);
    tx_next = tx_cnt;
    if (tx_err_ev) begin
      if (tx_sum > (TX_W+1)'(TX_MAX)) tx_next = TX_W'(TX_MAX);
      else                            tx_next = tx_sum[TX_W-1:0];
    end else if (tx_good_ev && (tx_cnt != '0)) begin
      tx_next = tx_cnt - TX_W'(1);
    end
  end

  // receive: all events summed, clamped to [0, RX_MAX]
  always_comb begin
    rx_up = {2'b00, rx_cnt} + SUM_W'(rx_err_ev)
          + (rx_dom_ev ? SUM_W'(RX_DOM_STEP) : SUM_W'(0));
    if (rx_good_ev && (rx_up != '0)) rx_dn = rx_up - SUM_W'(1);
    else                             rx_dn = rx_up;
    if (rx_dn > SUM_W'(RX_MAX)) rx_next = RX_W'(RX_MAX);
    else                        rx_next = rx_dn[RX_W-1:0];
  end

  assign boff_next = bus_off || (tx_next > TX_W'(BUSOFF_LIMIT));

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_cnt  <= '0;
      rx_cnt  <= '0;
      bus_off <= 1'b0;
    end else if (!bus_off) begin
      tx_cnt  <= tx_next;
      rx_cnt  <= rx_next;
      bus_off <= boff_next;
    end
  end
endmodule

// File: rtl/can_fc_flags.sv
module can_fc_flags
  import can_fc_pkg::*;
#(
  parameter int TX_W          = 9,
  parameter int RX_W          = 8,
  parameter int WARN_LIMIT    = 96,
  parameter int PASSIVE_LIMIT = 128,
  parameter int VIEW_MAX      = 255
) (
  input  logic               [TX_W-1:0]   tx_cnt,
  input  logic               [RX_W-1:0]   rx_cnt,
  input  logic                            bus_off,
  output conf_flags_t                     flags,
  output logic               [TEC_FW-1:0] tx_view
);
  logic tx_warn, rx_warn, tx_pass, rx_pass;

  always_comb begin
    tx_warn = tx_cnt >= TX_W'(WARN_LIMIT);
    rx_warn = rx_cnt >= RX_W'(WARN_LIMIT);
    tx_pass = tx_cnt >= TX_W'(PASSIVE_LIMIT);
    rx_pass = rx_cnt >= RX_W'(PASSIVE_LIMIT);
    flags.boff   = bus_off;
    flags.warn   = tx_warn || rx_warn;
    flags.epass  = (tx_pass || rx_pass) && !bus_off;
    flags.rxpass = rx_pass;
    if (tx_cnt > TX_W'(VIEW_MAX)) tx_view = TEC_FW'(VIEW_MAX);
    else                          tx_view = tx_cnt[TEC_FW-1:0];
  end
endmodule

// File: rtl/can_fc_irq_regs.sv
module can_fc_irq_regs
  import can_fc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RX_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tx_done,
  input  logic                rx_done,
  input  logic                lec_valid,
  input  logic [LEC_W-1:0]    lec_code,
  input  logic                err_ie,
  input  logic                stat_ie,
  input  logic                stat_wr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                rd_en,
  input  logic                rd_addr,
  input  conf_flags_t         flags,
  input  logic [TEC_FW-1:0]   tx_view,
  input  logic [RX_W-1:0]     rx_cnt,
  output logic [DATA_W-1:0]   rd_data,
  output logic                irq
);
  localparam int FW = LEC_W + 2;

  stat_fields_t st_q, st_base, st_next;
  logic         warn_q, boff_q;
  logic         err_chg, stat_chg, stat_rd, pend_next;
  logic [DATA_W-1:0] stat_word, cnt_word, rd_mux;

  // software write applied first, engine events on top of it
  always_comb begin
    st_base = stat_wr ? stat_fields_t'(wr_data[FW-1:0]) : st_q;
    st_next = st_base;
    if (tx_done)   st_next.txok = 1'b1;
    if (rx_done)   st_next.rxok = 1'b1;
    if (lec_valid) st_next.lec  = lec_code;
  end

  assign stat_chg  = (st_next != st_base);
  assign err_chg   = (flags.warn != warn_q) || (flags.boff != boff_q);
  assign stat_rd   = rd_en && (rd_addr == ADDR_STAT);
  assign pend_next = (irq && !stat_rd)
                   || (err_chg && err_ie)
                   || (stat_chg && stat_ie);

  always_comb begin
    stat_word = '0;
    stat_word[ST_LEC_LSB +: LEC_W] = st_q.lec;
    stat_word[ST_TXOK]  = st_q.txok;
    stat_word[ST_RXOK]  = st_q.rxok;
    stat_word[ST_EPASS] = flags.epass;
    stat_word[ST_WARN]  = flags.warn;
    stat_word[ST_BOFF]  = flags.boff;
    cnt_word = '0;
    cnt_word[TEC_LSB +: TEC_FW] = tx_view;
    cnt_word[REC_LSB +: REC_FW] = rx_cnt[REC_FW-1:0];
    cnt_word[CW_RXPASS]         = flags.rxpass;
    rd_mux = (rd_addr == ADDR_STAT) ? stat_word : cnt_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= '0;
      warn_q  <= 1'b0;
      boff_q  <= 1'b0;
      irq     <= 1'b0;
      rd_data <= '0;
    end else begin
      st_q    <= st_next;
      warn_q  <= flags.warn;
      boff_q  <= flags.boff;
      irq     <= pend_next;
      if (rd_en) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/can_fault_status.sv
module can_fault_status
  import can_fc_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int TX_W          = 9,
  parameter int RX_W          = 8,
  parameter int TX_STEP       = 8,
  parameter int RX_DOM_STEP   = 8,
  parameter int WARN_LIMIT    = 96,
  parameter int PASSIVE_LIMIT = 128,
  parameter int BUSOFF_LIMIT  = 255
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_done,
  input  logic              rx_done,
  input  logic              lec_valid,
  input  logic [2:0]        lec_code,
  input  logic              tx_err_ev,
  input  logic              tx_good_ev,
  input  logic              rx_err_ev,
  input  logic              rx_dom_ev,
  input  logic              rx_good_ev,
  input  logic              err_ie,
  input  logic              stat_ie,
  input  logic              stat_wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic [TX_W-1:0]   tx_cnt;
  logic [RX_W-1:0]   rx_cnt;
  logic              bus_off;
  conf_flags_t       flags;
  logic [TEC_FW-1:0] tx_view;
  logic              warn_flag;

  assign warn_flag = flags.warn;

  can_fc_counters #(
    .TX_W(TX_W), .RX_W(RX_W), .TX_STEP(TX_STEP),
    .RX_DOM_STEP(RX_DOM_STEP), .BUSOFF_LIMIT(BUSOFF_LIMIT)
  ) u_cnt (
    .clk(clk), .rst(rst),
    .tx_err_ev(tx_err_ev), .tx_good_ev(tx_good_ev),
    .rx_err_ev(rx_err_ev), .rx_dom_ev(rx_dom_ev), .rx_good_ev(rx_good_ev),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .bus_off(bus_off)
  );

  can_fc_flags #(
    .TX_W(TX_W), .RX_W(RX_W), .WARN_LIMIT(WARN_LIMIT),
    .PASSIVE_LIMIT(PASSIVE_LIMIT), .VIEW_MAX(BUSOFF_LIMIT)
  ) u_flags (
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .bus_off(bus_off),
    .flags(flags), .tx_view(tx_view)
  );

  can_fc_irq_regs #(
    .DATA_W(DATA_W), .RX_W(RX_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .tx_done(tx_done), .rx_done(rx_done),
    .lec_valid(lec_valid), .lec_code(lec_code),
    .err_ie(err_ie), .stat_ie(stat_ie),
    .stat_wr(stat_wr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .flags(flags), .tx_view(tx_view), .rx_cnt(rx_cnt),
    .rd_data(rd_data), .irq(irq)
  );
endmodule

// File: rtl/can_fc_checker.sv
module can_fc_checker #(
  parameter int TX_W = 9,
  parameter int RX_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            rd_en,
  input logic            rd_addr,
  input logic            irq,
  input logic            err_ie,
  input logic            stat_ie,
  input logic [TX_W-1:0] tx_cnt,
  input logic [RX_W-1:0] rx_cnt,
  input logic            bus_off,
  input logic            warn_flag,
  input logic            rx_err_ev,
  input logic            rx_dom_ev,
  input logic            rx_good_ev
);
  p_busoff_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    bus_off |=> bus_off);

  p_busoff_warn_r5: assert property (@(posedge clk) disable iff (rst)
    bus_off |-> warn_flag);

  p_irq_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (irq && !(rd_en && rd_addr == 1'b0)) |=> irq);

  p_irq_enabled_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(err_ie) || $past(stat_ie)));

  p_tx_down_by_one_r2: assert property (@(posedge clk) disable iff (rst)
    (tx_cnt < $past(tx_cnt)) |-> (tx_cnt == $past(tx_cnt) - TX_W'(1)));

  p_rx_has_cause_r3: assert property (@(posedge clk) disable iff (rst)
    (rx_cnt != $past(rx_cnt)) |-> ($past(rx_err_ev) || $past(rx_dom_ev) || $past(rx_good_ev)));
endmodule

bind can_fault_status can_fc_checker #(.TX_W(TX_W), .RX_W(RX_W)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .irq(irq),
  .err_ie(err_ie), .stat_ie(stat_ie), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .bus_off(bus_off), .warn_flag(warn_flag),
  .rx_err_ev(rx_err_ev), .rx_dom_ev(rx_dom_ev), .rx_good_ev(rx_good_ev)
);

// File: tb/can_fault_status_test.sv
`timescale 1ns/1ps
module can_fault_status_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_done = 0, rx_done = 0, lec_valid = 0;
  logic [2:0] lec_code = '0;
  logic tx_err_ev = 0, tx_good_ev = 0, rx_err_ev = 0, rx_dom_ev = 0, rx_good_ev = 0;
  logic err_ie = 0, stat_ie = 0, stat_wr = 0;
  logic [31:0] wr_data = '0;
  logic rd_en = 0, rd_addr = 0;
  logic [31:0] rd_data;
  logic irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] v;

  always #2 clk = ~clk;

  can_fault_status uut (
    .clk(clk), .rst(rst), .tx_done(tx_done), .rx_done(rx_done),
    .lec_valid(lec_valid), .lec_code(lec_code),
    .tx_err_ev(tx_err_ev), .tx_good_ev(tx_good_ev), .rx_err_ev(rx_err_ev),
    .rx_dom_ev(rx_dom_ev), .rx_good_ev(rx_good_ev),
    .err_ie(err_ie), .stat_ie(stat_ie), .stat_wr(stat_wr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  // {tx_err, tx_good, rx_err, rx_dom, rx_good}, expected tx, expected rx
  localparam logic [21:0] VEC [9] = '{
    {5'b01000, 9'd0,  8'd0},
    {5'b10000, 9'd8,  8'd0},
    {5'b11000, 9'd16, 8'd0},
    {5'b01000, 9'd15, 8'd0},
    {5'b00100, 9'd15, 8'd1},
    {5'b00010, 9'd15, 8'd9},
    {5'b00111, 9'd15, 8'd17},
    {5'b00001, 9'd15, 8'd16},
    {5'b10001, 9'd23, 8'd15}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc();
    cyc();
    rst = 1'b0;
  endtask

  task automatic cnt_ev(input logic [4:0] e);
    {tx_err_ev, tx_good_ev, rx_err_ev, rx_dom_ev, rx_good_ev} = e;
    cyc();
    {tx_err_ev, tx_good_ev, rx_err_ev, rx_dom_ev, rx_good_ev} = '0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    rd_en = 1'b1;
    rd_addr = a;
    cyc();
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic lec_ev(input logic [2:0] c);
    lec_valid = 1'b1;
    lec_code = c;
    cyc();
    lec_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 rd_data", rd_data, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(1'b0, v); chk("R1 status word", v, 32'h0);
    rd(1'b1, v); chk("R1 counter word", v, 32'h0);

    // R2 R3 R7 table of counter steps
    foreach (VEC[i]) begin
      cnt_ev(VEC[i][21:17]);
      rd(1'b1, v);
      chk($sformatf("R2/R3 row %0d", i), v,
          {16'b0, VEC[i][7], VEC[i][6:0], VEC[i][15:8]});
    end
    // R13 hold: counter moves, no read, rd_data unchanged
    cnt_ev(5'b10000);
    chk("R13 hold", rd_data, {16'b0, 1'b0, 7'd15, 8'd23});

    // R5 R9 warning via transmit counter
    do_reset();
    err_ie = 1'b1;
    repeat (11) cnt_ev(5'b10000);
    cyc();
    chk("R9 no irq below 96", {31'b0, irq}, 32'h0);
    cnt_ev(5'b10000);
    chk("R9 irq one edge later", {31'b0, irq}, 32'h0);
    cyc();
    chk("R9 irq on warn", {31'b0, irq}, 32'h1);
    rd(1'b1, v); chk("R12 counter read keeps irq", {31'b0, irq}, 32'h1);
    rd(1'b0, v); chk("R5 warn bit", v, 32'h40);
    chk("R12 status read clears", {31'b0, irq}, 32'h0);

    // R6 R11 error passive change without irq
    repeat (4) cnt_ev(5'b10000);
    cyc();
    chk("R11 epass no irq", {31'b0, irq}, 32'h0);
    rd(1'b0, v); chk("R6 epass+warn", v, 32'h60);
    rd(1'b1, v); chk("R7 tx 128", v, 32'h80);

    // R4 bus-off
    repeat (16) cnt_ev(5'b10000);
    cyc();
    chk("R4 busoff irq", {31'b0, irq}, 32'h1);
    rd(1'b0, v); chk("R4 busoff status", v, 32'hC0);
    rd(1'b1, v); chk("R7 tx view 255", v, 32'hFF);
    cnt_ev(5'b01111);
    cnt_ev(5'b00010);
    rd(1'b1, v); chk("R4 frozen", v, 32'hFF);
    rd(1'b0, v); chk("R4 sticky", v, 32'hC0);

    // R8 R10 R11 R12 status change interrupts
    do_reset();
    err_ie = 1'b0;
    stat_ie = 1'b1;
    tx_done = 1'b1; cyc(); tx_done = 1'b0;
    chk("R10 txok irq", {31'b0, irq}, 32'h1);
    rd(1'b0, v); chk("R8 txok bit", v, 32'h08);
    chk("R12 cleared", {31'b0, irq}, 32'h0);
    stat_wr = 1'b1; wr_data = 32'hFFFF_FF15; cyc(); stat_wr = 1'b0;
    cyc();
    chk("R11 write no irq", {31'b0, irq}, 32'h0);
    rd(1'b0, v); chk("R8 write fields", v, 32'h15);
    lec_ev(3'd5);
    chk("R10 same code no irq", {31'b0, irq}, 32'h0);
    lec_ev(3'd3);
    chk("R10 lec irq", {31'b0, irq}, 32'h1);
    // event in same cycle as status read
    lec_valid = 1'b1; lec_code = 3'd6; rd_en = 1'b1; rd_addr = 1'b0;
    cyc();
    lec_valid = 1'b0; rd_en = 1'b0;
    chk("R12 collide keeps irq", {31'b0, irq}, 32'h1);
    chk("R13 old value", rd_data, 32'h13);
    rd(1'b0, v); chk("R8 lec 6", v, 32'h16);
    chk("R12 cleared again", {31'b0, irq}, 32'h0);
    stat_ie = 1'b0;
    lec_ev(3'd1);
    rx_done = 1'b0;
    cyc();
    chk("R10 disabled", {31'b0, irq}, 32'h0);

    // R3 R5 R6 R7 receive side
    do_reset();
    stat_ie = 1'b0;
    err_ie = 1'b1;
    cnt_ev(5'b00001);
    rd(1'b1, v); chk("R3 rx floor", v, 32'h0);
    repeat (12) cnt_ev(5'b00010);
    cyc();
    chk("R5 rx warn irq", {31'b0, irq}, 32'h1);
    rd(1'b1, v); chk("R7 rx 96", v, 32'h6000);
    rd(1'b0, v); chk("R5 rx warn status", v, 32'h40);
    repeat (4) cnt_ev(5'b00010);
    cyc();
    chk("R11 rx epass no irq", {31'b0, irq}, 32'h0);
    rd(1'b1, v); chk("R6 rxpass bit", v, 32'h8000);
    rd(1'b0, v); chk("R6 rx epass", v, 32'h60);
    repeat (16) cnt_ev(5'b00010);
    rd(1'b1, v); chk("R3 rx clamp 255", v, 32'hFF00);
    err_ie = 1'b0;
    repeat (3) cnt_ev(5'b00010);
    cyc();
    chk("R9 disabled", {31'b0, irq}, 32'h0);

    finish_run();
  end
endmodule